// File: doc/BRIEF.md
# Priority Scheduling Buffer for an Accelerator Core

This block sits in front of one large core in an asymmetric multi-core chip. Small cores ship requests to run a contended code region (a lock-protected section, a barrier tail, a slow pipeline stage) on the large core. Each request carries an identifier for the code region, its entry PC, a stack pointer and the number of the small core that sent it. All hardware thread contexts of the large core share the buffer. It has one slot per small core, so a small core never has to wait for a slot.

Requests do not leave in arrival order. An outside unit measures how many cycles other threads have spent waiting on each region, and it supplies a priority for every slot. The slot with the highest priority is the head. The buffer issues the head to a free context of the large core once the head is ready to run. A context stays busy until the large core reports that the region has returned.

A ready request may be stuck behind a head that is not ready. If it stays stuck for a programmable number of cycles, the buffer sends it back to the small core that sent it, which then runs it there. This keeps independent regions from being held in order behind each other, and it prevents starvation.

Top module: `bneck_sched_buf`

## Requirements
- R1: After reset the buffer is in this state: every slot is empty, `reqReady` is 1, `issueValid` and `bounceValid` are 0, and every context is free.
- R2: When `reqValid` and `reqReady` are both high at a clock edge, the request is written into the empty slot with the lowest index. From the next cycle that slot shows `slotValid` high and its identifier on `slotBid`.
- R3: `reqReady` is 0 exactly when all slots are occupied. A `reqValid` seen while the buffer is full changes no slot.
- R4: The head is the occupied slot with the largest unsigned `slotPrio`; among equal priorities the lowest index wins. `issueValid` is high when the head's `slotReady` is 1 and a context is free. The issue outputs then carry the head's payload, and the slot is empty from the next cycle.
- R5: An issue takes the free context with the lowest index, shown on `issueCtx`. That context stays busy until `retValid` arrives with its index. Nothing issues while every context is busy. A context freed at an edge can take an issue in the next cycle.
- R6: If the head is not ready, nothing issues, even when other slots are ready.
- R7: A slot that is not the head counts the consecutive cycles in which it was occupied and ready. If `slotReady` drops, or the slot becomes the head, the count returns to 0. In a cycle where a slot is ready, is not the head, and its count is at least `bounceLimit`, it is returned: `bounceValid` goes high with that slot's payload, and the slot is empty from the next cycle. When several slots qualify, the lowest index goes first, one slot per cycle.
- R8: An insertion can share a cycle with an issue or a return, and each of them takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bounceLimit | input | CNT_W | Number of blocked ready cycles before a slot is returned |
| reqValid | input | 1 | New request offered |
| reqReady | output | 1 | At least one slot is empty |
| reqBid | input | BID_W | Region identifier of the request |
| reqPc | input | PC_W | Entry PC of the request |
| reqSp | input | SP_W | Stack pointer of the request |
| reqCore | input | CORE_W | Originating small core |
| slotValid | output | NUM_SMALL | Occupancy of each slot |
| slotBid | output | NUM_SMALL*BID_W | Region identifier held in each slot |
| slotPrio | input | NUM_SMALL*PRIO_W | Waiting-cycle priority of each slot |
| slotReady | input | NUM_SMALL | Each slot's region can start now |
| issueValid | output | 1 | Head is issued this cycle |
| issueCtx | output | CTX_W | Context receiving the issue |
| issueBid | output | BID_W | Issued identifier |
| issuePc | output | PC_W | Issued PC |
| issueSp | output | SP_W | Issued stack pointer |
| issueCore | output | CORE_W | Issued originating core |
| retValid | input | 1 | A context finished its region |
| retCtx | input | CTX_W | Context that finished |
| bounceValid | output | 1 | A slot is returned this cycle |
| bounceBid | output | BID_W | Returned identifier |
| bouncePc | output | PC_W | Returned PC |
| bounceSp | output | SP_W | Returned stack pointer |
| bounceCore | output | CORE_W | Small core that takes the request back |

## Verification
The assertions assume that `retValid` names only a context that is busy, and that `retCtx` is below the number of contexts. They also assume that the large core accepts every issue and each small core accepts every return in the cycle it is shown. The stimulus keeps to these rules: it takes return indices from its own model of busy contexts, and it never stalls an issue or a return. Priorities are drawn from a narrow range, so ties occur often. Readiness is random, and limits are small, so returns happen regularly.

// File: rtl/bsb_pkg.sv
package bsb_pkg;
  localparam int SLOT_IDX_W = 6;

  typedef struct packed {
    logic                  ins;
    logic [SLOT_IDX_W-1:0] insIdx;
    logic                  dsp;
    logic [SLOT_IDX_W-1:0] dspIdx;
    logic                  bnc;
    logic [SLOT_IDX_W-1:0] bncIdx;
  } slotStrobe_t;
endpackage

// File: rtl/bsb_slots.sv
module bsb_slots
  import bsb_pkg::*;
#(
  parameter int N      = 4,
  parameter int BID_W  = 16,
  parameter int PC_W   = 32,
  parameter int SP_W   = 32,
  parameter int CORE_W = 2,
  parameter int CNT_W  = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  slotStrobe_t                strobe,
  input  logic [BID_W-1:0]           inBid,
  input  logic [PC_W-1:0]            inPc,
  input  logic [SP_W-1:0]            inSp,
  input  logic [CORE_W-1:0]          inCore,
  input  logic [N-1:0]               readyIn,
  input  logic [$clog2(N)-1:0]       headIdx,
  input  logic                       headFound,
  input  logic [CNT_W-1:0]           bounceLimit,
  output logic [N-1:0]               validOut,
  output logic [N-1:0][BID_W-1:0]    bidOut,
  output logic [N-1:0]               overLimit,
  output logic [BID_W-1:0]           dspBid,
  output logic [PC_W-1:0]            dspPc,
  output logic [SP_W-1:0]            dspSp,
  output logic [CORE_W-1:0]          dspCore,
  output logic [BID_W-1:0]           bncBid,
  output logic [PC_W-1:0]            bncPc,
  output logic [SP_W-1:0]            bncSp,
  output logic [CORE_W-1:0]          bncCore
);
  localparam int IDX_W = $clog2(N);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [N-1:0]              validQ;
  logic [N-1:0][BID_W-1:0]   bidQ;
  logic [N-1:0][PC_W-1:0]    pcQ;
  logic [N-1:0][SP_W-1:0]    spQ;
  logic [N-1:0][CORE_W-1:0]  coreQ;
  logic [N-1:0][CNT_W-1:0]   cntQ;

  logic [IDX_W-1:0] insIdxL, dspIdxL, bncIdxL;
  assign insIdxL = strobe.insIdx[IDX_W-1:0];
  assign dspIdxL = strobe.dspIdx[IDX_W-1:0];
  assign bncIdxL = strobe.bncIdx[IDX_W-1:0];

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic insHit, dspHit, bncHit, isHead, countOn;
    assign insHit  = strobe.ins && (insIdxL == IDX_W'(i));
    assign dspHit  = strobe.dsp && (dspIdxL == IDX_W'(i));
    assign bncHit  = strobe.bnc && (bncIdxL == IDX_W'(i));
    assign isHead  = headFound && (headIdx == IDX_W'(i));
    assign countOn = validQ[i] && readyIn[i] && !isHead && !dspHit && !bncHit;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[i] <= 1'b0;
        cntQ[i]   <= '0;
      end else begin
        if (insHit) begin
          validQ[i] <= 1'b1;
        end else if (dspHit || bncHit) begin
          validQ[i] <= 1'b0;
        end
        if (insHit || !countOn) begin
          cntQ[i] <= '0;
        end else if (cntQ[i] != CNT_MAX) begin
          cntQ[i] <= cntQ[i] + 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (insHit) begin
        bidQ[i]  <= inBid;
        pcQ[i]   <= inPc;
        spQ[i]   <= inSp;
        coreQ[i] <= inCore;
      end
    end

    assign overLimit[i] = validQ[i] && (cntQ[i] >= bounceLimit);
  end

  assign validOut = validQ;
  assign bidOut   = bidQ;

  assign dspBid  = bidQ[dspIdxL];
  assign dspPc   = pcQ[dspIdxL];
  assign dspSp   = spQ[dspIdxL];
  assign dspCore = coreQ[dspIdxL];
  assign bncBid  = bidQ[bncIdxL];
  assign bncPc   = pcQ[bncIdxL];
  assign bncSp   = spQ[bncIdxL];
  assign bncCore = coreQ[bncIdxL];

  // R2: an insertion lands in an empty slot and occupies it next cycle
  p_ins_empty_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ins |-> !validQ[insIdxL]);
  p_ins_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ins |=> validQ[$past(insIdxL)]);
  // R4: an issued slot is empty in the following cycle
  p_issue_frees_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dsp |=> !validQ[$past(dspIdxL)]);
  // R7: returned slot is occupied and never the issued one
  p_bounce_distinct_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.bnc |-> (validQ[bncIdxL] && !(strobe.dsp && dspIdxL == bncIdxL)));
endmodule

// File: rtl/bsb_ctrl.sv
module bsb_ctrl
  import bsb_pkg::*;
#(
  parameter int N       = 4,
  parameter int PRIO_W  = 16,
  parameter int NUM_CTX = 2,
  parameter int CTX_W   = 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic [N-1:0]             slotValid,
  input  logic [N-1:0][PRIO_W-1:0] slotPrio,
  input  logic [N-1:0]             slotReady,
  input  logic [N-1:0]             overLimit,
  input  logic                     retValid,
  input  logic [CTX_W-1:0]         retCtx,
  output slotStrobe_t              strobe,
  output logic                     reqReady,
  output logic                     issueValid,
  output logic [CTX_W-1:0]         issueCtx,
  output logic                     bounceValid,
  output logic [$clog2(N)-1:0]     headIdx,
  output logic                     headFound
);
  localparam int IDX_W = $clog2(N);

  logic [NUM_CTX-1:0] ctxBusy;
  logic [IDX_W-1:0]   freeIdx, bncIdx;
  logic               freeFound, ctxFound;

  always_comb begin
    headIdx   = '0;
    headFound = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (slotValid[i] && (!headFound || slotPrio[i] > slotPrio[headIdx])) begin
        headIdx   = IDX_W'(i);
        headFound = 1'b1;
      end
    end
  end

  always_comb begin
    freeIdx   = '0;
    freeFound = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!slotValid[i] && !freeFound) begin
        freeIdx   = IDX_W'(i);
        freeFound = 1'b1;
      end
    end
  end

  always_comb begin
    issueCtx = '0;
    ctxFound = 1'b0;
    for (int c = 0; c < NUM_CTX; c++) begin
      if (!ctxBusy[c] && !ctxFound) begin
        issueCtx = CTX_W'(c);
        ctxFound = 1'b1;
      end
    end
  end

  always_comb begin
    bncIdx      = '0;
    bounceValid = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!bounceValid && overLimit[i] && slotReady[i] && (IDX_W'(i) != headIdx)) begin
        bncIdx      = IDX_W'(i);
        bounceValid = 1'b1;
      end
    end
  end

  assign reqReady   = freeFound;
  assign issueValid = headFound && slotReady[headIdx] && ctxFound;

  always_comb begin
    strobe        = '0;
    strobe.ins    = reqValid && freeFound;
    strobe.insIdx = SLOT_IDX_W'(freeIdx);
    strobe.dsp    = issueValid;
    strobe.dspIdx = SLOT_IDX_W'(headIdx);
    strobe.bnc    = bounceValid;
    strobe.bncIdx = SLOT_IDX_W'(bncIdx);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctxBusy <= '0;
    end else begin
      for (int c = 0; c < NUM_CTX; c++) begin
        if (issueValid && issueCtx == CTX_W'(c)) begin
          ctxBusy[c] <= 1'b1;
        end else if (retValid && retCtx == CTX_W'(c)) begin
          ctxBusy[c] <= 1'b0;
        end
      end
    end
  end

  // R3: a full buffer refuses requests
  p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rstN)
    (&slotValid) |-> !reqReady);
  // R5: a returned context is free in the next cycle
  p_ret_frees_r5: assert property (@(posedge clk) disable iff (!rstN)
    retValid |=> !ctxBusy[$past(retCtx)]);
  // R5: an issued context is busy in the next cycle
  p_issue_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |=> ctxBusy[$past(issueCtx)]);
  // R6: an issue always concerns an occupied ready slot
  p_issue_ready_r6: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> (slotValid[headIdx] && slotReady[headIdx]));
endmodule

// File: rtl/bneck_sched_buf.sv
module bneck_sched_buf
  import bsb_pkg::*;
#(
  parameter int NUM_SMALL = 4,
  parameter int BID_W     = 16,
  parameter int PC_W      = 32,
  parameter int SP_W      = 32,
  parameter int PRIO_W    = 16,
  parameter int NUM_CTX   = 2,
  parameter int CNT_W     = 8,
  localparam int CORE_W   = $clog2(NUM_SMALL),
  localparam int CTX_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [CNT_W-1:0]                 bounceLimit,
  input  logic                             reqValid,
  output logic                             reqReady,
  input  logic [BID_W-1:0]                 reqBid,
  input  logic [PC_W-1:0]                  reqPc,
  input  logic [SP_W-1:0]                  reqSp,
  input  logic [CORE_W-1:0]                reqCore,
  output logic [NUM_SMALL-1:0]             slotValid,
  output logic [NUM_SMALL-1:0][BID_W-1:0]  slotBid,
  input  logic [NUM_SMALL-1:0][PRIO_W-1:0] slotPrio,
  input  logic [NUM_SMALL-1:0]             slotReady,
  output logic                             issueValid,
  output logic [CTX_W-1:0]                 issueCtx,
  output logic [BID_W-1:0]                 issueBid,
  output logic [PC_W-1:0]                  issuePc,
  output logic [SP_W-1:0]                  issueSp,
  output logic [CORE_W-1:0]                issueCore,
  input  logic                             retValid,
  input  logic [CTX_W-1:0]                 retCtx,
  output logic                             bounceValid,
  output logic [BID_W-1:0]                 bounceBid,
  output logic [PC_W-1:0]                  bouncePc,
  output logic [SP_W-1:0]                  bounceSp,
  output logic [CORE_W-1:0]                bounceCore
);
  slotStrobe_t                  strobe;
  logic [NUM_SMALL-1:0]         overLimit;
  logic [$clog2(NUM_SMALL)-1:0] headIdx;
  logic                         headFound;

  bsb_ctrl #(
    .N(NUM_SMALL), .PRIO_W(PRIO_W), .NUM_CTX(NUM_CTX), .CTX_W(CTX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .slotValid(slotValid),
    .slotPrio(slotPrio), .slotReady(slotReady), .overLimit(overLimit),
    .retValid(retValid), .retCtx(retCtx), .strobe(strobe), .reqReady(reqReady),
    .issueValid(issueValid), .issueCtx(issueCtx), .bounceValid(bounceValid),
    .headIdx(headIdx), .headFound(headFound)
  );

  bsb_slots #(
    .N(NUM_SMALL), .BID_W(BID_W), .PC_W(PC_W), .SP_W(SP_W),
    .CORE_W(CORE_W), .CNT_W(CNT_W)
  ) u_slots (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inBid(reqBid), .inPc(reqPc),
    .inSp(reqSp), .inCore(reqCore), .readyIn(slotReady), .headIdx(headIdx),
    .headFound(headFound), .bounceLimit(bounceLimit), .validOut(slotValid),
    .bidOut(slotBid), .overLimit(overLimit), .dspBid(issueBid), .dspPc(issuePc),
    .dspSp(issueSp), .dspCore(issueCore), .bncBid(bounceBid), .bncPc(bouncePc),
    .bncSp(bounceSp), .bncCore(bounceCore)
  );

  // R8: insertion and issue in one cycle never target the same slot
  p_ins_dsp_apart_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ins && strobe.dsp) |-> (strobe.insIdx != strobe.dspIdx));
endmodule

// File: tb/bneck_sched_buf_tb.sv
module bneck_sched_buf_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int NC = 2;

  logic clk = 0;
  logic rstN = 0;
  logic [7:0] bounceLimit = 8'd200;
  logic reqValid = 0;
  logic reqReady;
  logic [15:0] reqBid = 0;
  logic [31:0] reqPc = 0, reqSp = 0;
  logic [1:0] reqCore = 0;
  logic [N-1:0] slotValid;
  logic [N-1:0][15:0] slotBid;
  logic [N-1:0][15:0] slotPrio = '0;
  logic [N-1:0] slotReady = '0;
  logic issueValid;
  logic [0:0] issueCtx;
  logic [15:0] issueBid;
  logic [31:0] issuePc, issueSp;
  logic [1:0] issueCore;
  logic retValid = 0;
  logic [0:0] retCtx = 0;
  logic bounceValid;
  logic [15:0] bounceBid;
  logic [31:0] bouncePc, bounceSp;
  logic [1:0] bounceCore;

  bneck_sched_buf u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  bit mValid[N];
  logic [15:0] mBid[N];
  logic [31:0] mPc[N], mSp[N];
  logic [1:0] mCore[N];
  int mCnt[N];
  bit mBusy[NC];
  int eHead, eIns, eCtx, eBnc;
  bit eFound, eIssue, eReady, eBounce, eCtxFree;
  bit lastIssue;
  logic [15:0] lastIssueBid;
  int lastIssueCtx;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic evalModel();
    eFound = 0; eHead = 0;
    for (int i = 0; i < N; i++)
      if (mValid[i] && (!eFound || slotPrio[i] > slotPrio[eHead])) begin eHead = i; eFound = 1; end
    eReady = 0; eIns = 0;
    for (int i = N-1; i >= 0; i--) if (!mValid[i]) begin eIns = i; eReady = 1; end
    eCtxFree = 0; eCtx = 0;
    for (int c = NC-1; c >= 0; c--) if (!mBusy[c]) begin eCtx = c; eCtxFree = 1; end
    eIssue = eFound && slotReady[eHead] && eCtxFree;
    eBounce = 0; eBnc = 0;
    for (int i = N-1; i >= 0; i--)
      if (mValid[i] && i != eHead && slotReady[i] && mCnt[i] >= int'(bounceLimit)) begin
        eBnc = i; eBounce = 1;
      end
  endtask

  task automatic step();
    #1;
    evalModel();
    chk("R3 reqReady", reqReady, eReady);
    for (int i = 0; i < N; i++) begin
      chk("R2 slotValid", slotValid[i], mValid[i]);
      if (mValid[i]) chk("R2 slotBid", slotBid[i], mBid[i]);
    end
    chk("R4 R6 issueValid", issueValid, eIssue);
    if (eIssue) begin
      chk("R5 issueCtx", issueCtx, eCtx);
      chk("R4 issueBid", issueBid, mBid[eHead]);
      chk("R4 issuePc", issuePc, mPc[eHead]);
      chk("R4 issueSp", issueSp, mSp[eHead]);
      chk("R4 issueCore", issueCore, mCore[eHead]);
    end
    chk("R7 bounceValid", bounceValid, eBounce);
    if (eBounce) begin
      chk("R7 bounceBid", bounceBid, mBid[eBnc]);
      chk("R7 bouncePc", bouncePc, mPc[eBnc]);
      chk("R7 bounceSp", bounceSp, mSp[eBnc]);
      chk("R7 bounceCore", bounceCore, mCore[eBnc]);
    end
    lastIssue = issueValid; lastIssueBid = issueBid; lastIssueCtx = int'(issueCtx);
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      if (mValid[i] && !(eIssue && i == eHead) && !(eBounce && i == eBnc)) begin
        if (slotReady[i] && !(eFound && i == eHead)) begin
          if (mCnt[i] < 255) mCnt[i]++;
        end else mCnt[i] = 0;
      end
    end
    if (eIssue) mValid[eHead] = 0;
    if (eBounce) mValid[eBnc] = 0;
    if (reqValid && eReady) begin
      mValid[eIns] = 1; mBid[eIns] = reqBid; mPc[eIns] = reqPc;
      mSp[eIns] = reqSp; mCore[eIns] = reqCore; mCnt[eIns] = 0;
    end
    if (retValid) mBusy[retCtx] = 0;
    if (eIssue) mBusy[eCtx] = 1;
    @(negedge clk);
  endtask

  task automatic setReq(bit v, logic [15:0] b);
    reqValid = v; reqBid = b; reqPc = {16'hC0DE, b}; reqSp = {16'h5AC0, b}; reqCore = b[1:0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin mValid[i] = 0; mCnt[i] = 0; end
    for (int c = 0; c < NC; c++) mBusy[c] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    chk("R1 reqReady", reqReady, 1);
    chk("R1 issueValid", issueValid, 0);
    chk("R1 bounceValid", bounceValid, 0);
    chk("R1 slotValid", slotValid, 0);

    // fill, nothing ready
    for (int k = 0; k < N; k++) begin setReq(1, 16'h0010 + 16'(k)); step(); end
    setReq(1, 16'h0099); step();
    chk("R3 full unchanged", slotValid, 4'b1111);
    chk("R3 slot3 bid kept", slotBid[3], 16'h0013);
    setReq(0, 0);

    // head (slot2) not ready, others ready
    slotPrio = '0; slotPrio[2] = 16'd5; slotPrio[0] = 1; slotPrio[1] = 1; slotPrio[3] = 1;
    slotReady = 4'b1011;
    step();
    chk("R6 no issue behind blocked head", lastIssue, 0);
    bounceLimit = 8'd2;
    repeat (3) step();
    chk("R7 slots 0 and 1 returned", slotValid, 4'b1100);

    // insertion together with issue
    bounceLimit = 8'd200; slotReady = 4'b0111;
    setReq(1, 16'h0020);
    step();
    chk("R8 issue same cycle", lastIssueBid, 16'h0012);
    chk("R8 occupancy after", slotValid, 4'b1001);
    setReq(0, 0);

    // contexts: slot3 to ctx1, then all busy
    slotPrio[3] = 16'd9; slotReady = 4'b1111;
    step();
    chk("R5 second ctx", lastIssueCtx, 1);
    step();
    chk("R5 all busy no issue", lastIssue, 0);
    retValid = 1; retCtx = 0;
    step();
    chk("R5 no issue in return cycle", lastIssue, 0);
    retValid = 0;
    step();
    chk("R5 issue after return", lastIssue, 1);
    chk("R5 freed ctx reused", lastIssueCtx, 0);

    // ties: fill with equal priority, all ready, ctx1 freed
    retValid = 1; retCtx = 1; step(); retValid = 0;
    retValid = 1; retCtx = 0; step(); retValid = 0;
    slotPrio = '0; slotReady = 4'b0000;
    for (int k = 0; k < N; k++) begin setReq(1, 16'h0030 + 16'(k)); step(); end
    setReq(0, 0); slotReady = 4'b1111;
    step();
    chk("R4 tie lowest index", lastIssueBid, 16'h0030);

    // random phase
    for (int cyc = 0; cyc < 4000; cyc++) begin
      setReq(($urandom % 3) != 0, 16'($urandom));
      for (int i = 0; i < N; i++) begin
        slotPrio[i] = 16'($urandom % 4);
        slotReady[i] = ($urandom % 10) < 7;
      end
      bounceLimit = 8'($urandom % 4);
      retValid = 0;
      if (($urandom % 3) == 0) begin
        int pick = int'($urandom % NC);
        for (int c = 0; c < NC; c++)
          if (!retValid && mBusy[(pick + c) % NC]) begin
            retValid = 1; retCtx = 1'((pick + c) % NC);
          end
      end
      step();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule